// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned operands and raises exactly one of three flags: the first operand is larger, the second is larger, or the two are the same. It is purely combinational. Internally the operands are cut into narrow slices; each slice judges its own bits and, only when its own bits tie, hands on the verdict it received from the slice below it. The most significant slice therefore has the final say, and the verdict that enters the least significant slice acts as a tie-breaker.

That entry verdict is exposed as three cascade inputs. Driving them with "equal" gives a plain comparison; driving them from the outputs of another instance of this block chains instances into an even wider comparator, with this instance as the more significant part.

Top module: `cmp_chain`

## Requirements
- R1: When operand A is numerically greater than operand B, the outputs are gt=1, lt=0, eq=0, whatever the cascade inputs carry.
- R2: When A is numerically less than B, the outputs are gt=0, lt=1, eq=0, whatever the cascade inputs carry.
- R3: When A equals B, each output equals its cascade input (gt_o=cin_gt_i, lt_o=cin_lt_i, eq_o=cin_eq_i).
- R4: Whenever exactly one cascade input is high, exactly one output is high.
- R5: With the cascade inputs held at gt=0, lt=0, eq=1, the block is a plain unsigned comparator, eq_o being high only for identical operands.
- R6: A difference in a more significant slice decides the result even when a less significant slice differs the other way.
- R7: Cascade patterns that are not one-hot (for example gt=lt=1, or all zero) pass through unchanged when the operands are equal.
- R8: The outputs are a combinational function of the present inputs; no clock edge is needed for a change at the inputs to reach them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | SLICE_W*SLICES | Operand A, unsigned |
| b_i | input | SLICE_W*SLICES | Operand B, unsigned |
| cin_gt_i | input | 1 | Lower-order verdict: A side larger |
| cin_lt_i | input | 1 | Lower-order verdict: B side larger |
| cin_eq_i | input | 1 | Lower-order verdict: tie |
| gt_o | output | 1 | A is greater |
| lt_o | output | 1 | A is less |
| eq_o | output | 1 | A and B equal (under the cascade verdict) |

## Verification
Operand pairs that differ only in the lowest slice and only in the highest slice separate a chain that truly propagates from one that looks at a single slice. Pairs whose slices disagree in direction (higher slice larger, lower slice smaller) show that precedence goes to the most significant difference. Equal operands under each cascade pattern, including non-one-hot ones, show pass-through, while unequal operands under a contrary cascade verdict show that the cascade is ignored. A walking single bit on either side exercises every bit position of every slice.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_res_t;

    localparam cmp_res_t CMP_TIE = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};

endpackage

// File: rtl/cmp_local.sv
module cmp_local
    import cmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output cmp_res_t     res_o
);

    logic [W-1:0] bit_gt;
    logic [W-1:0] bit_lt;
    cmp_res_t     res_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_gt[i] = a_i[i] & ~b_i[i];
        assign bit_lt[i] = ~a_i[i] & b_i[i];
    end

    // Scan upward; the highest differing bit is written last and wins.
    always_comb begin
        res_d = CMP_TIE;
        for (int i = 0; i < W; i++) begin
            if (bit_gt[i] | bit_lt[i]) begin
                res_d.gt = bit_gt[i];
                res_d.lt = bit_lt[i];
                res_d.eq = 1'b0;
            end
        end
    end

    assign res_o = res_d;

endmodule

// File: rtl/cmp_merge.sv
module cmp_merge
    import cmp_pkg::*;
(
    input  cmp_res_t local_i,
    input  cmp_res_t casc_i,
    output cmp_res_t res_o
);

    cmp_res_t res_d;

    // A local tie defers to the lower-order verdict; otherwise the local one stands.
    always_comb begin
        if (local_i.eq) res_d = casc_i;
        else            res_d = local_i;
    end

    assign res_o = res_d;

endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
    import cmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  cmp_res_t     casc_i,
    output cmp_res_t     res_o
);

    cmp_res_t local_res;

    cmp_local #(.W(W)) u_local (
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (local_res)
    );

    cmp_merge u_merge (
        .local_i (local_res),
        .casc_i  (casc_i),
        .res_o   (res_o)
    );

endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
    import cmp_pkg::*;
#(
    parameter int SLICE_W = 4,
    parameter int SLICES  = 4
) (
    input  logic [SLICE_W*SLICES-1:0] a_i,
    input  logic [SLICE_W*SLICES-1:0] b_i,
    input  logic                      cin_gt_i,
    input  logic                      cin_lt_i,
    input  logic                      cin_eq_i,
    output logic                      gt_o,
    output logic                      lt_o,
    output logic                      eq_o
);

    localparam int DATA_W = SLICE_W * SLICES;

    cmp_res_t link [SLICES+1];

    assign link[0] = '{gt: cin_gt_i, lt: cin_lt_i, eq: cin_eq_i};

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        cmp_slice #(.W(SLICE_W)) u_slice (
            .a_i    (a_i[s*SLICE_W +: SLICE_W]),
            .b_i    (b_i[s*SLICE_W +: SLICE_W]),
            .casc_i (link[s]),
            .res_o  (link[s+1])
        );
    end

    assign gt_o = link[SLICES].gt;
    assign lt_o = link[SLICES].lt;
    assign eq_o = link[SLICES].eq;

    if (DATA_W < 1) begin : g_bad_width
        $error("cmp_chain: empty operand width");
    end

endmodule

// File: rtl/cmp_chain_chk.sv
module cmp_chain_chk #(
    parameter int SLICE_W = 4,
    parameter int SLICES  = 4
) (
    input logic [SLICE_W*SLICES-1:0] a_i,
    input logic [SLICE_W*SLICES-1:0] b_i,
    input logic                      cin_gt_i,
    input logic                      cin_lt_i,
    input logic                      cin_eq_i,
    input logic                      gt_o,
    input logic                      lt_o,
    input logic                      eq_o
);

    always_comb begin
        if (a_i > b_i) begin
            p_greater_r1: assert (gt_o && !lt_o && !eq_o)
                else $error("R1: A>B but flags %b%b%b", gt_o, lt_o, eq_o);
        end
        if (a_i < b_i) begin
            p_less_r2: assert (!gt_o && lt_o && !eq_o)
                else $error("R2: A<B but flags %b%b%b", gt_o, lt_o, eq_o);
        end
        if (a_i == b_i) begin
            p_pass_r3: assert (gt_o == cin_gt_i && lt_o == cin_lt_i && eq_o == cin_eq_i)
                else $error("R3: tie did not pass cascade through");
        end
        if ($onehot({cin_gt_i, cin_lt_i, cin_eq_i})) begin
            p_onehot_r4: assert ($onehot({gt_o, lt_o, eq_o}))
                else $error("R4: flags not one-hot");
        end
    end

endmodule

bind cmp_chain cmp_chain_chk #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .cin_gt_i (cin_gt_i),
    .cin_lt_i (cin_lt_i),
    .cin_eq_i (cin_eq_i),
    .gt_o     (gt_o),
    .lt_o     (lt_o),
    .eq_o     (eq_o)
);

// File: tb/sim_cmp_chain.sv
`timescale 1ns/1ps
module sim_cmp_chain;

    localparam int SW = 4;
    localparam int NS = 4;
    localparam int DW = SW * NS;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [2:0]    cin;   // {gt, lt, eq}
        logic [2:0]    exp;   // {gt, lt, eq}
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{16'h1234, 16'h1234, 3'b001, 3'b001},  // R5 plain tie
        '{16'h8000, 16'h7FFF, 3'b001, 3'b100},  // R6 top slice beats lower ones
        '{16'h0001, 16'h0000, 3'b001, 3'b100},  // R1 lowest slice decides
        '{16'h0000, 16'hFFFF, 3'b001, 3'b010},  // R2
        '{16'hABCD, 16'hABCE, 3'b001, 3'b010},  // R2 low slice
        '{16'h1234, 16'h1234, 3'b100, 3'b100},  // R3
        '{16'h1234, 16'h1234, 3'b010, 3'b010},  // R3
        '{16'h5000, 16'h4FFF, 3'b010, 3'b100},  // R1 cascade ignored
        '{16'h4FFF, 16'h5000, 3'b100, 3'b010},  // R2 cascade ignored
        '{16'h0F0F, 16'h0F0F, 3'b110, 3'b110},  // R7
        '{16'hFFFF, 16'hFFFF, 3'b000, 3'b000},  // R7
        '{16'hFFFF, 16'hFFFF, 3'b001, 3'b001}   // R5
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] a, b;
    logic cgt, clt, ceq;
    logic gt, lt, eq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmp_chain #(.SLICE_W(SW), .SLICES(NS)) u0 (
        .a_i(a), .b_i(b),
        .cin_gt_i(cgt), .cin_lt_i(clt), .cin_eq_i(ceq),
        .gt_o(gt), .lt_o(lt), .eq_o(eq)
    );

    task automatic check(input string req, input logic [2:0] exp);
        n_run++;
        if ({gt, lt, eq} !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%b got %b expected %b",
                     req, a, b, {cgt, clt, ceq}, {gt, lt, eq}, exp);
        end
    endtask

    task automatic apply(input logic [DW-1:0] va, input logic [DW-1:0] vb,
                         input logic [2:0] vc);
        @(posedge clk);
        #1;
        a = va; b = vb; {cgt, clt, ceq} = vc;
        #1;  // combinational: settle, then sample before the next edge (R8)
    endtask

    initial begin
        a = '0; b = '0; {cgt, clt, ceq} = 3'b001;
        repeat (3) @(posedge clk);
        #1;
        check("R5 reset/idle tie", 3'b001);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].a, VECS[i].b, VECS[i].cin);
            check("R1/R2/R3/R5/R6/R7 table", VECS[i].exp);
        end

        // R8: change without any clock edge in between
        a = 16'h0002; b = 16'h0001; #1;
        check("R8 immediate gt", 3'b100);
        b = 16'h0003; #1;
        check("R8 immediate lt", 3'b010);

        // Walking bit, every position, against opposing cascade verdicts
        for (int k = 0; k < DW; k++) begin
            apply(DW'(1) << k, '0, 3'b010);
            check("R1 walking bit", 3'b100);
            apply('0, DW'(1) << k, 3'b100);
            check("R2 walking bit", 3'b010);
            apply(DW'(1) << k, DW'(1) << k, 3'b100);
            check("R3 walking tie", 3'b100);
        end

        // R6: higher slice larger, every lower slice smaller
        for (int s = 1; s < NS; s++) begin
            logic [DW-1:0] va, vb;
            va = (DW'(1) << (s*SW)) | DW'(0);
            vb = (DW'(1) << (s*SW)) - DW'(1);  // all lower bits set
            apply(va, vb, 3'b001);
            check("R6 precedence gt", 3'b100);
            apply(vb, va, 3'b001);
            check("R6 precedence lt", 3'b010);
        end

        // R4: every one-hot cascade on a tie and a non-tie
        for (int c = 0; c < 3; c++) begin
            logic [2:0] oh;
            oh = 3'b001 << c;
            apply(16'h7777, 16'h7777, oh);
            check("R4 one-hot tie", oh);
            apply(16'h7778, 16'h7777, oh);
            check("R4 one-hot gt", 3'b100);
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule